// File: doc/BRIEF.md
# Shared DMA Buffer Pool Allocator

This block owns a pool of two equal FIFO buffers and lends them to two independent DMA engines. Each buffer holds 16 words of 32 bits (128 bytes across the pool). An engine signals that it is running by holding its active line high. The allocator then decides which buffers that engine may stage data in, and so how long a burst it can build up. An engine that runs alone gets the whole pool. When both run, one of three sharing policies chosen by a mode input decides how the pool is split.

Engines move data through per-engine write and read ports. Each port carries a buffer select, so an engine holding both buffers can steer traffic to either one. Each buffer can be written and read in the same cycle, so a burst of any length can stream through a single buffer. A buffer changes hands only after it has drained. While a buffer is waiting to be taken from its owner it refuses new writes, and the owner still reads out what is left. Per buffer, the block exposes the owner, a drain-pending flag, the fill level, full and empty flags and both pointers.

Top module: `dma_buf_pool`

## Requirements
- R1: After reset no buffer is owned, both buffers are empty, every level is 0 and every pointer is 0.
- R2: An engine that is active while the other is idle is granted both free buffers at the first clock edge after its active input rises.
- R3: A buffer that holds data keeps its owner, even after that owner drops its active input or the policy wants the buffer back.
- R4: An owned buffer that is due to be released and is empty becomes unowned at the next edge. A free buffer goes to an active engine still short of its quota at the edge after that.
- R5: With arb_mode 0 or 3 (equal sharing) and both engines active, each engine's quota is one buffer. An engine holding two gives up buffer 1. Until that handover, buf_draining for buffer 1 is 1 and writes to it are refused.
- R6: With arb_mode 1 (first come, first served) and both engines active, the engine that became active first keeps both buffers and the other gets none. If both become active in the same cycle, engine 0 counts as first.
- R7: With arb_mode 2 (fixed priority) and both engines active, engine 1 wins only when eng_hipri is 2'b10; otherwise engine 0 wins. The winner's quota is both buffers and the loser's is none, so the loser's buffers drain and move to the winner.
- R8: A write is accepted only when the writing engine owns the selected buffer, that buffer is not draining and it is not full. Any other write leaves the level unchanged.
- R9: rd_data of an engine is the oldest word of the selected buffer (first-word fall-through) when the engine owns that buffer, and zero otherwise. A read removes a word only when the engine owns the buffer and it is not empty.
- R10: A write and a read to the same buffer in one cycle leave the level unchanged and advance both pointers, so a stream longer than the pool comes out complete and in order.
- R11: A buffer is full at level 16 and empty at level 0. Its pointers wrap modulo 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_mode | input | 2 | Sharing policy: 0/3 equal, 1 first come first served, 2 fixed priority |
| eng_active | input | 2 | Per-engine active (request) line |
| eng_hipri | input | 2 | Per-engine priority bit used in fixed-priority mode |
| wr_en | input | 2 | Per-engine write strobe |
| wr_sel | input | 2 | Per-engine target buffer for writes |
| wr_data | input | 64 | Per-engine write word, engine e at bits [32e+31:32e] |
| rd_en | input | 2 | Per-engine read strobe |
| rd_sel | input | 2 | Per-engine source buffer for reads |
| rd_data | output | 64 | Per-engine oldest word of the selected buffer, or zero |
| buf_owned | output | 2 | Per-buffer owned flag |
| buf_owner | output | 2 | Per-buffer owning engine index |
| buf_draining | output | 2 | Per-buffer release pending; writes refused |
| buf_level | output | 10 | Per-buffer occupancy, 5 bits each |
| buf_full | output | 2 | Per-buffer full flag |
| buf_empty | output | 2 | Per-buffer empty flag |
| buf_wr_ptr | output | 8 | Per-buffer fill pointer, 4 bits each |
| buf_rd_ptr | output | 8 | Per-buffer drain pointer, 4 bits each |

## Verification
A corrupted ownership register shows up on buf_owner and buf_owned at the very next sample. It also shows up as rd_data falling to zero for the real owner. A quota computed wrongly surfaces as a grant or release one edge early or late, so the bench checks every handover at the exact edge. A level or pointer that has gone wrong breaks the fall-through word order, and a long stream through one buffer exposes it within one wrap of 16 words.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  localparam int NUM_ENG = 2;
  localparam int NUM_BUF = 2;

  typedef enum logic [1:0] {
    ARB_EQUAL     = 2'd0,
    ARB_FIRST     = 2'd1,
    ARB_FIXED     = 2'd2,
    ARB_EQUAL_ALT = 2'd3
  } arb_mode_e;
endpackage

// File: rtl/dbp_fifo.sv
module dbp_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     pop,
  output logic [DATA_W-1:0]        rdata,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     full,
  output logic                     empty,
  output logic [$clog2(DEPTH)-1:0] wr_ptr,
  output logic [$clog2(DEPTH)-1:0] rd_ptr
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LW-1:0]     level_q, level_d;
  logic              ptr_en;

  always_comb begin
    wr_ptr_d = wr_ptr_q + AW'(push);
    rd_ptr_d = rd_ptr_q + AW'(pop);
    level_d  = level_q + LW'(push) - LW'(pop);
    ptr_en   = push | pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (ptr_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_ptr_q] <= wdata;
  end

  assign rdata  = mem_q[rd_ptr_q];
  assign level  = level_q;
  assign full   = (level_q == LW'(DEPTH));
  assign empty  = (level_q == '0);
  assign wr_ptr = wr_ptr_q;
  assign rd_ptr = rd_ptr_q;

  assert_level_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(DEPTH));
  assert_ptr_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    AW'(wr_ptr_q - rd_ptr_q) == level_q[AW-1:0]);
  assert_push_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/dbp_policy.sv
module dbp_policy
  import dbp_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [1:0]                      arb_mode,
  input  logic [NUM_ENG-1:0]              eng_active,
  input  logic [NUM_ENG-1:0]              eng_hipri,
  output logic [NUM_ENG-1:0][CNT_W-1:0]   target
);
  localparam logic [CNT_W-1:0] QUOTA_ALL  = CNT_W'(NUM_BUF);
  localparam logic [CNT_W-1:0] QUOTA_HALF = CNT_W'(NUM_BUF / 2);

  logic [NUM_ENG-1:0] act_q;
  logic               first_q, first_eff, first_en;
  logic               fixed_win;
  arb_mode_e          mode;

  assign mode = arb_mode_e'(arb_mode);

  always_comb begin
    unique case (eng_active)
      2'b01:   first_eff = 1'b0;
      2'b10:   first_eff = 1'b1;
      2'b11:   first_eff = (act_q == '0) ? 1'b0 : first_q;
      default: first_eff = first_q;
    endcase
    first_en  = |eng_active;
    fixed_win = (eng_hipri == 2'b10);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      first_q <= 1'b0;
    end else begin
      act_q <= eng_active;
      if (first_en) first_q <= first_eff;
    end
  end

  always_comb begin
    target = '0;
    unique case (eng_active)
      2'b01: target[0] = QUOTA_ALL;
      2'b10: target[1] = QUOTA_ALL;
      2'b11: begin
        unique case (mode)
          ARB_FIRST: target[first_eff] = QUOTA_ALL;
          ARB_FIXED: target[fixed_win] = QUOTA_ALL;
          default: begin
            target[0] = QUOTA_HALF;
            target[1] = QUOTA_HALF;
          end
        endcase
      end
      default: target = '0;
    endcase
  end
endmodule

// File: rtl/dbp_alloc.sv
module dbp_alloc
  import dbp_pkg::*;
#(
  parameter int CNT_W = 2,
  parameter int EID_W = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_ENG-1:0][CNT_W-1:0]   target,
  input  logic [NUM_BUF-1:0]              buf_empty,
  input  logic [NUM_ENG-1:0]              eng_active,
  output logic [NUM_BUF-1:0]              owned,
  output logic [NUM_BUF-1:0][EID_W-1:0]   owner,
  output logic [NUM_BUF-1:0]              draining
);
  logic [NUM_BUF-1:0]              own_q, own_d;
  logic [NUM_BUF-1:0][EID_W-1:0]   owner_q, owner_d;
  logic [NUM_ENG-1:0][CNT_W-1:0]   held, need;
  logic [NUM_BUF-1:0][CNT_W-1:0]   rank;
  logic                            got, alloc_en;

  always_comb begin
    held = '0;
    for (int b = 0; b < NUM_BUF; b++)
      for (int e = 0; e < NUM_ENG; e++)
        if (own_q[b] && owner_q[b] == EID_W'(e)) held[e] = held[e] + CNT_W'(1);

    for (int b = 0; b < NUM_BUF; b++) begin
      rank[b] = '0;
      for (int j = 0; j <= b; j++)
        if (own_q[j] && owner_q[j] == owner_q[b]) rank[b] = rank[b] + CNT_W'(1);
      draining[b] = own_q[b] && (rank[b] > target[owner_q[b]]);
    end

    for (int e = 0; e < NUM_ENG; e++)
      need[e] = (target[e] > held[e]) ? (target[e] - held[e]) : '0;

    own_d   = own_q;
    owner_d = owner_q;
    for (int b = 0; b < NUM_BUF; b++) begin
      got = 1'b0;
      if (own_q[b]) begin
        if (draining[b] && buf_empty[b]) own_d[b] = 1'b0;
      end else begin
        for (int e = 0; e < NUM_ENG; e++) begin
          if (!got && need[e] != '0) begin
            own_d[b]   = 1'b1;
            owner_d[b] = EID_W'(e);
            need[e]    = need[e] - CNT_W'(1);
            got        = 1'b1;
          end
        end
      end
    end
    alloc_en = (own_d != own_q) || (owner_d != owner_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q   <= '0;
      owner_q <= '0;
    end else if (alloc_en) begin
      own_q   <= own_d;
      owner_q <= owner_d;
    end
  end

  assign owned = own_q;
  assign owner = owner_q;

  logic [NUM_ENG-1:0] act_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_seen_q <= '0;
    else        act_seen_q <= eng_active;
  end

  for (genvar gb = 0; gb < NUM_BUF; gb++) begin : g_chk
    assert_hold_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q[gb] && !buf_empty[gb]) |=> (own_q[gb] && owner_q[gb] == $past(owner_q[gb])));
    assert_free_is_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !own_q[gb] |-> buf_empty[gb]);
    assert_grant_to_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q[gb] && !$past(own_q[gb])) |-> act_seen_q[owner_q[gb]]);
  end
endmodule

// File: rtl/dma_buf_pool.sv
module dma_buf_pool
  import dbp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [1:0]                             arb_mode,
  input  logic [NUM_ENG-1:0]                     eng_active,
  input  logic [NUM_ENG-1:0]                     eng_hipri,
  input  logic [NUM_ENG-1:0]                     wr_en,
  input  logic [NUM_ENG*$clog2(NUM_BUF)-1:0]     wr_sel,
  input  logic [NUM_ENG*DATA_W-1:0]              wr_data,
  input  logic [NUM_ENG-1:0]                     rd_en,
  input  logic [NUM_ENG*$clog2(NUM_BUF)-1:0]     rd_sel,
  output logic [NUM_ENG*DATA_W-1:0]              rd_data,
  output logic [NUM_BUF-1:0]                     buf_owned,
  output logic [NUM_BUF*$clog2(NUM_ENG)-1:0]     buf_owner,
  output logic [NUM_BUF-1:0]                     buf_draining,
  output logic [NUM_BUF*($clog2(DEPTH)+1)-1:0]   buf_level,
  output logic [NUM_BUF-1:0]                     buf_full,
  output logic [NUM_BUF-1:0]                     buf_empty,
  output logic [NUM_BUF*$clog2(DEPTH)-1:0]       buf_wr_ptr,
  output logic [NUM_BUF*$clog2(DEPTH)-1:0]       buf_rd_ptr
);
  localparam int AW     = $clog2(DEPTH);
  localparam int LW     = AW + 1;
  localparam int BSEL_W = $clog2(NUM_BUF);
  localparam int EID_W  = $clog2(NUM_ENG);
  localparam int CNT_W  = $clog2(NUM_BUF + 1);

  logic [NUM_ENG-1:0][CNT_W-1:0]  target;
  logic [NUM_BUF-1:0]             own, drain, full, empty, push, pop;
  logic [NUM_BUF-1:0][EID_W-1:0]  owner;
  logic [NUM_BUF-1:0][DATA_W-1:0] bdata;
  logic [NUM_BUF-1:0][DATA_W-1:0] bwdata;
  logic [BSEL_W-1:0]              rsel;

  dbp_policy #(.CNT_W(CNT_W)) policy_i (
    .clk(clk), .rst_n(rst_n), .arb_mode(arb_mode),
    .eng_active(eng_active), .eng_hipri(eng_hipri), .target(target)
  );

  dbp_alloc #(.CNT_W(CNT_W), .EID_W(EID_W)) alloc_i (
    .clk(clk), .rst_n(rst_n), .target(target), .buf_empty(empty),
    .eng_active(eng_active), .owned(own), .owner(owner), .draining(drain)
  );

  always_comb begin
    push   = '0;
    pop    = '0;
    bwdata = '0;
    for (int b = 0; b < NUM_BUF; b++) begin
      for (int e = 0; e < NUM_ENG; e++) begin
        if (own[b] && owner[b] == EID_W'(e)) begin
          if (wr_en[e] && wr_sel[e*BSEL_W +: BSEL_W] == BSEL_W'(b)) begin
            push[b]   = 1'b1;
            bwdata[b] = wr_data[e*DATA_W +: DATA_W];
          end
          if (rd_en[e] && rd_sel[e*BSEL_W +: BSEL_W] == BSEL_W'(b)) pop[b] = 1'b1;
        end
      end
      push[b] = push[b] && !drain[b] && !full[b];
      pop[b]  = pop[b] && !empty[b];
    end
  end

  always_comb begin
    rd_data = '0;
    rsel    = '0;
    for (int e = 0; e < NUM_ENG; e++) begin
      rsel = rd_sel[e*BSEL_W +: BSEL_W];
      if (own[rsel] && owner[rsel] == EID_W'(e)) rd_data[e*DATA_W +: DATA_W] = bdata[rsel];
    end
  end

  for (genvar gb = 0; gb < NUM_BUF; gb++) begin : g_buf
    dbp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
      .clk(clk), .rst_n(rst_n), .push(push[gb]), .wdata(bwdata[gb]),
      .pop(pop[gb]), .rdata(bdata[gb]), .level(buf_level[gb*LW +: LW]),
      .full(full[gb]), .empty(empty[gb]),
      .wr_ptr(buf_wr_ptr[gb*AW +: AW]), .rd_ptr(buf_rd_ptr[gb*AW +: AW])
    );
    assign buf_owner[gb*EID_W +: EID_W] = owner[gb];

    assert_draining_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (drain[gb] && !full[gb]) |=> (buf_level[gb*LW +: LW] <= $past(buf_level[gb*LW +: LW])));
  end

  assign buf_owned    = own;
  assign buf_draining = drain;
  assign buf_full     = full;
  assign buf_empty    = empty;
endmodule

// File: tb/dma_buf_pool_tb_top.sv
module dma_buf_pool_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  arb_mode, eng_active, eng_hipri, wr_en, wr_sel, rd_en, rd_sel;
  logic [63:0] wr_data, rd_data;
  logic [1:0]  buf_owned, buf_owner, buf_draining, buf_full, buf_empty;
  logic [9:0]  buf_level;
  logic [7:0]  buf_wr_ptr, buf_rd_ptr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dma_buf_pool dut_i (
    .clk(clk), .rst_n(rst_n), .arb_mode(arb_mode), .eng_active(eng_active),
    .eng_hipri(eng_hipri), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .buf_owned(buf_owned),
    .buf_owner(buf_owner), .buf_draining(buf_draining), .buf_level(buf_level),
    .buf_full(buf_full), .buf_empty(buf_empty), .buf_wr_ptr(buf_wr_ptr),
    .buf_rd_ptr(buf_rd_ptr)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] lvl(input int b);
    return buf_level[b*5 +: 5];
  endfunction

  task automatic wr1(input int e, input int b, input logic [31:0] d);
    wr_en[e] = 1'b1; wr_sel[e] = b[0]; wr_data[e*32 +: 32] = d;
    step();
    wr_en[e] = 1'b0;
  endtask

  task automatic rd1(input int e, input int b);
    rd_en[e] = 1'b1; rd_sel[e] = b[0];
    step();
    rd_en[e] = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 owned", 32'(buf_owned), 32'h0);
    chk("R1 empty", 32'(buf_empty), 32'h3);
    chk("R1 levels", 32'(buf_level), 32'h0);
    chk("R1 pointers", {buf_wr_ptr, buf_rd_ptr}, 32'h0);
  endtask

  task automatic t_lone_fill();
    arb_mode = 2'd0; eng_active = 2'b01;
    step();
    chk("R2 owned", 32'(buf_owned), 32'h3);
    chk("R2 owner", 32'(buf_owner), 32'h0);
    wr1(1, 0, 32'hbad0);
    chk("R8 non-owner write", 32'(lvl(0)), 32'd0);
    for (int i = 0; i < 16; i++) wr1(0, 0, 32'(100 + i));
    chk("R11 full", 32'(buf_full[0]), 32'h1);
    chk("R11 level 16", 32'(lvl(0)), 32'd16);
    chk("R11 wr_ptr wrap", 32'(buf_wr_ptr[3:0]), 32'h0);
    wr1(0, 0, 32'hdead);
    chk("R8 write to full", 32'(lvl(0)), 32'd16);
    rd_sel[1] = 1'b0;
    #0;
    chk("R9 non-owner rd_data", rd_data[63:32], 32'h0);
    for (int i = 0; i < 16; i++) begin
      chk("R9 rd order", rd_data[31:0], 32'(100 + i));
      rd1(0, 0);
    end
    chk("R11 empty", 32'(buf_empty[0]), 32'h1);
    rd1(0, 0);
    chk("R9 read of empty", 32'(lvl(0)), 32'd0);
  endtask

  task automatic t_equal_share();
    wr1(0, 1, 32'h55);
    eng_active = 2'b11;
    step();
    chk("R5 draining", 32'(buf_draining), 32'h2);
    repeat (3) step();
    chk("R3 kept with data", {30'd0, buf_owned[1], buf_owner[1]}, 32'h2);
    wr1(0, 1, 32'h66);
    chk("R5 write refused", 32'(lvl(1)), 32'd1);
    rd_sel[0] = 1'b1;
    #0;
    chk("R9 rd buf1", rd_data[31:0], 32'h55);
    rd1(0, 1);
    chk("R4 not yet released", 32'(buf_owned), 32'h3);
    step();
    chk("R4 released", 32'(buf_owned), 32'h1);
    step();
    chk("R5 each one buffer", {28'd0, buf_owned, buf_owner}, 32'hE);
    wr1(1, 1, 32'h77);
    chk("R8 owner write", 32'(lvl(1)), 32'd1);
    eng_active = 2'b01;
    repeat (3) step();
    chk("R3 idle owner keeps data", {30'd0, buf_owned[1], buf_owner[1]}, 32'h3);
    rd1(1, 1);
    chk("R4 pending", 32'(buf_owner[1]), 32'h1);
    step();
    chk("R4 freed", 32'(buf_owned[1]), 32'h0);
    step();
    chk("R4 regrant", {30'd0, buf_owned[1], buf_owner[1]}, 32'h2);
    eng_active = 2'b00;
    step();
    chk("R4 all released", 32'(buf_owned), 32'h0);
  endtask

  task automatic t_stream();
    eng_active = 2'b01;
    step();
    rd_sel[0] = 1'b0;
    wr1(0, 0, 32'd0);
    for (int i = 1; i < 40; i++) begin
      chk("R10 stream order", rd_data[31:0], 32'(i - 1));
      wr_en[0] = 1'b1; wr_sel[0] = 1'b0; wr_data[31:0] = 32'(i); rd_en[0] = 1'b1;
      step();
    end
    wr_en[0] = 1'b0; rd_en[0] = 1'b0;
    chk("R10 level steady", 32'(lvl(0)), 32'd1);
    chk("R10 last word", rd_data[31:0], 32'd39);
    chk("R11 ptr wrap", {24'd0, buf_wr_ptr[3:0], buf_rd_ptr[3:0]}, 32'h87);
    rd1(0, 0);
    eng_active = 2'b00;
    step();
    chk("R4 stream release", 32'(buf_owned), 32'h0);
  endtask

  task automatic t_first_come();
    arb_mode = 2'd1; eng_active = 2'b10;
    step();
    chk("R6 lone e1", {28'd0, buf_owned, buf_owner}, 32'hF);
    eng_active = 2'b11;
    repeat (4) step();
    chk("R6 first keeps", {28'd0, buf_owned, buf_owner}, 32'hF);
    chk("R6 no drain", 32'(buf_draining), 32'h0);
    eng_active = 2'b00;
    step();
    chk("R6 release", 32'(buf_owned), 32'h0);
    eng_active = 2'b11;
    step();
    chk("R6 tie to e0", {28'd0, buf_owned, buf_owner}, 32'hC);
    eng_active = 2'b00;
    step();
  endtask

  task automatic t_fixed();
    arb_mode = 2'd2; eng_hipri = 2'b10; eng_active = 2'b01;
    step();
    chk("R7 e0 alone", {28'd0, buf_owned, buf_owner}, 32'hC);
    eng_active = 2'b11;
    step();
    chk("R7 loser released", 32'(buf_owned), 32'h0);
    step();
    chk("R7 e1 wins", {28'd0, buf_owned, buf_owner}, 32'hF);
    eng_hipri = 2'b11;
    step();
    chk("R7 tie drops e1", 32'(buf_owned), 32'h0);
    step();
    chk("R7 e0 wins tie", {28'd0, buf_owned, buf_owner}, 32'hC);
    eng_active = 2'b00;
    step();
  endtask

  initial begin
    rst_n = 1'b0; arb_mode = '0; eng_active = '0; eng_hipri = '0;
    wr_en = '0; wr_sel = '0; wr_data = '0; rd_en = '0; rd_sel = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_lone_fill();
    t_equal_share();
    t_stream();
    t_first_come();
    t_fixed();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule